// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address, made of a 16-bit segment value and an offset, into a linear address. It keeps the six segment registers (code, stack, data and three extra data segments) and a small descriptor store that software fills. Each request names the kind of access it makes. The kind picks the default segment register, and an explicit override field in the request can replace that default.

After reset the unit is in real mode. In this mode the chosen segment value is shifted left by four bits and added to the low 16 bits of the offset. The result is a 20-bit address, and several segment:offset pairs can reach the same byte. Once software switches to protected mode, the same 16-bit value is a selector instead. The unit subtracts a table-base index from the selector's upper 13 bits to get a slot in the descriptor store. The slot's base is added to the 32-bit offset. An offset at or past the slot's size, or a slot outside the store, raises a fault in place of an address.

Each translation is registered. The result appears one cycle after the request, together with the privilege level of the descriptor that was used.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid and out_fault are 0, the unit is in real mode, all six segment registers hold 0 and the table base is 0.
- R2: In real mode, out_lin = ((segment << 4) + req_off[15:0]) mod 2^20 with bits 31:20 zero, so req_off[31:16] has no effect; distinct pairs such as A5C0:2DE1 and A5BF:2DF1 give the same address.
- R3: With no override, req_kind 0 (fetch) uses the code register (index 0), kind 1 (stack) uses the stack register (index 1), and kinds 2 and 3 (data) use the data register (index 2).
- R4: req_ovr values 0..5 select the registers code, stack, data, extra0, extra1, extra2 in that order; values 6 and 7 mean no override. sreg_sel uses the same indices, and a write with index 6 or 7 changes no register.
- R5: In protected mode, slot = (selector[15:3] - table base) mod 2^13, out_lin = (slot base + req_off) mod 2^32 and out_dpl = the slot's privilege level.
- R6: In protected mode, if req_off >= slot size, then out_fault = 1, out_valid = 0, out_lin = 0 and out_dpl = 0; req_off = size - 1 still translates.
- R7: In protected mode, a slot number of DEPTH or more (including a wrapped negative difference) gives the same fault result as R6.
- R8: Outputs are registered one cycle after req_valid. A cycle with req_valid low leaves out_valid and out_fault low in the next cycle, and out_valid and out_fault are never both 1.
- R9: A segment register, descriptor, table-base or mode write made in the same cycle as a request takes effect only for later requests.
- R10: In real mode out_fault is never raised and out_dpl is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode_we | input | 1 | Write the mode register |
| cfg_mode_prot | input | 1 | New mode: 1 protected, 0 real |
| cfg_tbl_we | input | 1 | Write the table-base index |
| cfg_tbl_base | input | 13 | New table-base index |
| sreg_we | input | 1 | Segment register write enable |
| sreg_sel | input | 3 | Segment register index (0..5) |
| sreg_data | input | 16 | Segment register write value |
| dsc_we | input | 1 | Descriptor slot write enable |
| dsc_idx | input | clog2(DEPTH) | Descriptor slot number |
| dsc_base | input | 32 | Descriptor base |
| dsc_size | input | 32 | Descriptor size (exclusive bound of the offset) |
| dsc_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2/3 data |
| req_ovr | input | 3 | Segment override, 6 or 7 for none |
| req_off | input | 32 | Offset |
| out_valid | output | 1 | Translation result valid |
| out_lin | output | 32 | Linear address |
| out_fault | output | 1 | Protection fault |
| out_dpl | output | 2 | Privilege level of the result |

## Verification
A configuration write and a translation can fall in the same cycle. A segment register, descriptor, table-base or mode update issued together with a request must not leak into that request. The bench provokes this both in directed cases and in random cycles where writes and requests are drawn independently. Its model computes each expected result from the register and descriptor state as it stood before the cycle's writes, and then applies the writes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 32;
  localparam int REAL_W = 20;
  localparam int NSEG   = 6;
  localparam int IDX_W  = 13;

  typedef enum logic [2:0] {
    SR_CODE = 3'd0, SR_STACK = 3'd1, SR_DATA = 3'd2,
    SR_EX0  = 3'd3, SR_EX1   = 3'd4, SR_EX2  = 3'd5
  } sreg_e;

  typedef enum logic [1:0] {
    AK_FETCH = 2'd0, AK_STACK = 2'd1, AK_DATA = 2'd2, AK_DATA_ALT = 2'd3
  } acc_e;

  typedef struct packed {
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] size;
    logic [1:0]       dpl;
  } desc_t;

  function automatic logic [2:0] kind_to_sreg(input logic [1:0] kind);
    case (acc_e'(kind))
      AK_FETCH: return SR_CODE;
      AK_STACK: return SR_STACK;
      default:  return SR_DATA;
    endcase
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int N = NSEG,
  parameter int W = SEG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [2:0]   wsel,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   kind,
  input  logic [2:0]   ovr,
  output logic [W-1:0] seg
);
  logic [W-1:0] regs [N];
  logic [2:0]   pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (wsel < 3'(N))) begin
      regs[wsel] <= wdata;
    end
  end

  always_comb begin
    pick = (ovr < 3'(N)) ? ovr : kind_to_sreg(kind);
    seg  = regs[pick];
  end

  // R4: an out-of-range write index leaves the register file untouched
  p_bad_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (we && wsel >= 3'(N)) |=> $stable(regs[0]) && $stable(regs[N-1]));
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  desc_t         wdesc,
  input  logic [AW-1:0] ridx,
  output desc_t         rdesc
);
  desc_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdesc;
  end

  assign rdesc = mem[ridx];
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_mode_we,
  input  logic                     cfg_mode_prot,
  input  logic                     cfg_tbl_we,
  input  logic [12:0]              cfg_tbl_base,
  input  logic                     sreg_we,
  input  logic [2:0]               sreg_sel,
  input  logic [15:0]              sreg_data,
  input  logic                     dsc_we,
  input  logic [$clog2(DEPTH)-1:0] dsc_idx,
  input  logic [31:0]              dsc_base,
  input  logic [31:0]              dsc_size,
  input  logic [1:0]               dsc_dpl,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [2:0]               req_ovr,
  input  logic [31:0]              req_off,
  output logic                     out_valid,
  output logic [31:0]              out_lin,
  output logic                     out_fault,
  output logic [1:0]               out_dpl
);
  localparam int AW = $clog2(DEPTH);

  logic             prot_q;
  logic [IDX_W-1:0] tbl_q;
  logic [SEG_W-1:0] seg;
  desc_t            wdesc, rdesc;
  logic [IDX_W-1:0] slot;
  logic             slot_ok, over;
  logic [REAL_W-1:0] real_lin;
  logic [OFF_W-1:0]  prot_lin;

  seg_regfile #(.N(NSEG), .W(SEG_W)) u_regs (
    .clk(clk), .rst(rst), .we(sreg_we), .wsel(sreg_sel), .wdata(sreg_data),
    .kind(req_kind), .ovr(req_ovr), .seg(seg)
  );

  assign wdesc = '{base: dsc_base, size: dsc_size, dpl: dsc_dpl};

  seg_desc_cache #(.DEPTH(DEPTH)) u_cache (
    .clk(clk), .we(dsc_we), .widx(dsc_idx), .wdesc(wdesc),
    .ridx(slot[AW-1:0]), .rdesc(rdesc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      tbl_q  <= '0;
    end else begin
      if (cfg_mode_we) prot_q <= cfg_mode_prot;
      if (cfg_tbl_we)  tbl_q  <= cfg_tbl_base;
    end
  end

  always_comb begin
    real_lin = {seg, 4'b0000} + REAL_W'(req_off[SEG_W-1:0]);
    slot     = seg[SEG_W-1:SEG_W-IDX_W] - tbl_q;
    slot_ok  = slot < IDX_W'(DEPTH);
    over     = req_off >= rdesc.size;
    prot_lin = rdesc.base + req_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_lin   <= '0;
      out_dpl   <= '0;
    end else begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_lin   <= '0;
      out_dpl   <= '0;
      if (req_valid) begin
        if (!prot_q) begin
          out_valid <= 1'b1;
          out_lin   <= OFF_W'(real_lin);
        end else if (!slot_ok || over) begin
          out_fault <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_lin   <= prot_lin;
          out_dpl   <= rdesc.dpl;
        end
      end
    end
  end

  p_fault_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(out_fault && out_valid));
  p_answer_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_valid || out_fault));
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_fault));
  p_real_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_q) |=> (out_valid && out_dpl == 2'd0 && out_lin[31:20] == 12'd0));
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (out_lin == 32'd0 && out_dpl == 2'd0));
  p_fault_only_prot_r7: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> $past(prot_q));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst;
  logic cfg_mode_we, cfg_mode_prot, cfg_tbl_we;
  logic [12:0] cfg_tbl_base;
  logic sreg_we;
  logic [2:0] sreg_sel;
  logic [15:0] sreg_data;
  logic dsc_we;
  logic [2:0] dsc_idx;
  logic [31:0] dsc_base, dsc_size;
  logic [1:0] dsc_dpl;
  logic req_valid;
  logic [1:0] req_kind;
  logic [2:0] req_ovr;
  logic [31:0] req_off;
  logic out_valid, out_fault;
  logic [31:0] out_lin;
  logic [1:0] out_dpl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_seg [6];
  logic [31:0] m_base [DEPTH];
  logic [31:0] m_size [DEPTH];
  logic [1:0]  m_dpl [DEPTH];
  logic        m_prot;
  logic [12:0] m_tbl;

  always #10 clk = ~clk;

  seg_xlate #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_prot(cfg_mode_prot),
    .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_base(cfg_tbl_base),
    .sreg_we(sreg_we), .sreg_sel(sreg_sel), .sreg_data(sreg_data),
    .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_base(dsc_base),
    .dsc_size(dsc_size), .dsc_dpl(dsc_dpl),
    .req_valid(req_valid), .req_kind(req_kind), .req_ovr(req_ovr), .req_off(req_off),
    .out_valid(out_valid), .out_lin(out_lin), .out_fault(out_fault), .out_dpl(out_dpl)
  );

  task automatic clear_in();
    cfg_mode_we = 0; cfg_mode_prot = 0; cfg_tbl_we = 0; cfg_tbl_base = '0;
    sreg_we = 0; sreg_sel = 0; sreg_data = '0;
    dsc_we = 0; dsc_idx = 0; dsc_base = '0; dsc_size = '0; dsc_dpl = '0;
    req_valid = 0; req_kind = 0; req_ovr = 3'd7; req_off = '0;
  endtask

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual v/f/dpl/lin=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result from the model state before this cycle's writes.
  function automatic logic [35:0] model_out();
    logic [2:0]  pick;
    logic [15:0] s;
    logic [12:0] slot;
    logic [19:0] rl;
    if (!req_valid) return '0;
    pick = (req_ovr < 3'd6) ? req_ovr : (req_kind == 2'd0 ? 3'd0 : req_kind == 2'd1 ? 3'd1 : 3'd2);
    s = m_seg[pick];
    if (!m_prot) begin
      rl = {s, 4'h0} + {4'h0, req_off[15:0]};
      return {1'b1, 1'b0, 2'd0, 12'd0, rl};
    end
    slot = s[15:3] - m_tbl;
    if (slot >= 13'(DEPTH) || req_off >= m_size[slot[2:0]]) return {1'b0, 1'b1, 2'd0, 32'd0};
    return {1'b1, 1'b0, m_dpl[slot[2:0]], m_base[slot[2:0]] + req_off};
  endfunction

  task automatic step(input string tag);
    logic [35:0] exp;
    exp = model_out();
    if (sreg_we && sreg_sel < 3'd6) m_seg[sreg_sel] = sreg_data;
    if (dsc_we) begin
      m_base[dsc_idx] = dsc_base; m_size[dsc_idx] = dsc_size; m_dpl[dsc_idx] = dsc_dpl;
    end
    if (cfg_mode_we) m_prot = cfg_mode_prot;
    if (cfg_tbl_we) m_tbl = cfg_tbl_base;
    @(posedge clk);
    @(negedge clk);
    check(tag, {out_valid, out_fault, out_dpl, out_lin}, exp);
    clear_in();
  endtask

  task automatic wr_seg(input logic [2:0] i, input logic [15:0] v);
    sreg_we = 1; sreg_sel = i; sreg_data = v;
    step("R1 idle");
  endtask

  task automatic wr_dsc(input logic [2:0] i, input logic [31:0] b, input logic [31:0] sz, input logic [1:0] d);
    dsc_we = 1; dsc_idx = i; dsc_base = b; dsc_size = sz; dsc_dpl = d;
    step("R8 idle");
  endtask

  task automatic rq(input string tag, input logic [1:0] k, input logic [2:0] o, input logic [31:0] off);
    req_valid = 1; req_kind = k; req_ovr = o; req_off = off;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20161));
    clear_in();
    rst = 1;
    for (int i = 0; i < 6; i++) m_seg[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin m_base[i] = '0; m_size[i] = '0; m_dpl[i] = '0; end
    m_prot = 0; m_tbl = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset outputs", {out_valid, out_fault, out_dpl, out_lin}, '0);
    rq("R1 zero segment real", 2'd2, 3'd7, 32'h0000_1234);

    // R2: formula, aliasing, wrap, ignored offset high bits
    wr_seg(3'd2, 16'hA5C0);
    rq("R2 alias a", 2'd2, 3'd7, 32'h0000_2DE1);
    check("R2 alias value", {out_valid, out_lin}, {1'b1, 32'h000A_89E1});
    wr_seg(3'd2, 16'hA5BF);
    rq("R2 alias b", 2'd2, 3'd7, 32'hFFFF_2DF1);
    check("R2 alias value b", {out_valid, out_lin}, {1'b1, 32'h000A_89E1});
    wr_seg(3'd2, 16'hFFFF);
    rq("R2 wrap", 2'd2, 3'd7, 32'h0000_FFFF);

    // R3 / R4: defaults and overrides
    for (int i = 0; i < 6; i++) wr_seg(3'(i), 16'h1000 * 16'(i + 1));
    for (int k = 0; k < 4; k++) rq("R3 default segment", 2'(k), 3'd7, 32'h0000_0010);
    for (int o = 0; o < 8; o++) rq("R4 override", 2'd0, 3'(o), 32'h0000_0020);
    wr_seg(3'd6, 16'hDEAD);
    wr_seg(3'd7, 16'hBEEF);
    for (int o = 0; o < 6; o++) rq("R4 bad index write ignored", 2'd1, 3'(o), 32'h0);

    // R9: segment write in the same cycle as a request
    req_valid = 1; req_kind = 2'd2; req_ovr = 3'd7; req_off = 32'h5;
    sreg_we = 1; sreg_sel = 3'd2; sreg_data = 16'h7777;
    step("R9 seg write same cycle");
    rq("R9 seg write after", 2'd2, 3'd7, 32'h5);

    // descriptors and table base, then mode switch together with a request (R9)
    for (int i = 0; i < DEPTH; i++)
      wr_dsc(3'(i), 32'h1000_0000 * 32'(i) + 32'h100, 32'h0000_1000 + 32'(i), 2'(i));
    cfg_tbl_we = 1; cfg_tbl_base = 13'd5;
    step("R1 idle");
    req_valid = 1; req_kind = 2'd0; req_ovr = 3'd7; req_off = 32'h40;
    cfg_mode_we = 1; cfg_mode_prot = 1;
    step("R9 mode write same cycle");

    // R5 / R6 / R7
    wr_seg(3'd3, {13'd7, 3'b101});
    rq("R5 protected translate", 2'd0, 3'd3, 32'h0000_0FFF);
    rq("R5 wrap 2^32", 2'd0, 3'd3, 32'h0000_0001);
    wr_dsc(3'd2, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 2'd3);
    rq("R5 wrap high base", 2'd0, 3'd3, 32'h0000_0020);
    wr_dsc(3'd2, 32'h2000, 32'h100, 2'd1);
    rq("R6 offset size-1 ok", 2'd0, 3'd3, 32'h0000_00FF);
    rq("R6 offset equal size", 2'd0, 3'd3, 32'h0000_0100);
    rq("R6 offset far past", 2'd0, 3'd3, 32'hFFFF_FFFF);
    wr_seg(3'd4, {13'd12, 3'b000});
    rq("R7 last slot", 2'd0, 3'd4, 32'h0);
    wr_seg(3'd4, {13'd13, 3'b000});
    rq("R7 slot equals depth", 2'd0, 3'd4, 32'h0);
    wr_seg(3'd4, {13'd4, 3'b000});
    rq("R7 slot below base", 2'd0, 3'd4, 32'h0);
    req_valid = 1; req_kind = 2'd0; req_ovr = 3'd3; req_off = 32'h10;
    dsc_we = 1; dsc_idx = 3'd2; dsc_base = 32'h9000; dsc_size = 32'h1; dsc_dpl = 2'd2;
    step("R9 descriptor write same cycle");
    req_valid = 1; req_kind = 2'd0; req_ovr = 3'd4; req_off = 32'h10;
    cfg_tbl_we = 1; cfg_tbl_base = 13'd4;
    step("R9 table write same cycle");
    rq("R9 table write after", 2'd0, 3'd4, 32'h10);

    // R8: idle cycle
    step("R8 no request");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 4 == 0) begin
        sreg_we = 1; sreg_sel = 3'($urandom % 7);
        sreg_data = {13'(m_tbl + 13'($urandom % 10)), 3'($urandom)};
        if ($urandom % 3 == 0) sreg_data = 16'($urandom);
      end
      if ($urandom % 5 == 0) begin
        dsc_we = 1; dsc_idx = 3'($urandom); dsc_base = $urandom;
        dsc_size = ($urandom % 2 == 0) ? 32'($urandom % 64) : $urandom; dsc_dpl = 2'($urandom);
      end
      if ($urandom % 40 == 0) begin cfg_mode_we = 1; cfg_mode_prot = 1'($urandom); end
      if ($urandom % 60 == 0) begin cfg_tbl_we = 1; cfg_tbl_base = 13'($urandom % 16); end
      req_valid = ($urandom % 4 != 0);
      req_kind = 2'($urandom);
      req_ovr = 3'($urandom);
      req_off = ($urandom % 2 == 0) ? 32'($urandom % 80) : $urandom;
      step(m_prot ? "R5 R6 R7 random protected" : "R2 R3 R4 random real");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule